// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Pending and Vector Unit

This unit holds the interrupt bookkeeping of a two-channel serial controller. For each channel it tracks whether a received character and a transmit-buffer-empty condition are waiting, and whether each is currently being serviced. From that it keeps a shared six-bit pending register, a modified interrupt vector naming the most recent source, and one active-high interrupt request formed from both channels.

The surrounding controller drives single-cycle strobes: a character arrived, the host read the data port, the host wrote the data port, the transmitter went empty. It also drives two command strobes, clear-transmit-pending and reset-highest-under-service. Enable bits and a status-high/status-low vector mode are level inputs. Receive service has precedence: while a received character is under service, a transmit event is remembered but does not take over the vector until the host issues reset-under-service or reads the character.

Top module: `sio_irq_vec`

## Requirements
- R1: After reset the pending register, the vector, the request and both status bits of each channel are 0.
- R2: A character-received strobe on a channel sets that channel's receive pending bit (bit 5 for channel A, bit 2 for channel B), marks receive under service and loads the receive vector code.
- R3: A transmit event (transmit-empty or data write) marks transmit pending. If receive is not under service it also marks transmit under service, loads the transmit vector and sets the transmit pending bit (bit 4 for A, bit 1 for B) when the transmit enable is set. If receive is under service, the vector and that pending bit are left unchanged.
- R4: Vector codes, taken from the mode input in the cycle of the update. Status-low: receive A 0x0C, receive B 0x04, transmit A 0x08, transmit B 0x00, none 0x06. Status-high: receive A 0x30, receive B 0x20, transmit A 0x10, transmit B 0x00, none 0x60.
- R5: A data-read strobe clears receive pending and under-service, clears the receive pending bit and loads the none code. If transmit is still pending, it instead marks transmit under service, loads the transmit code and sets the transmit pending bit when enabled.
- R6: Clear-transmit-pending clears transmit pending, under-service and its pending bit and loads the none code. If receive is still pending, it re-marks receive under service, sets its pending bit and loads the receive code.
- R7: Reset-under-service, with receive under service, clears that and, if transmit is pending, marks transmit under service, loads the transmit code and sets its pending bit when enabled. Without receive under service it clears transmit under service and leaves the vector unchanged.
- R8: The request output is registered. After each clock edge it is high when either channel has transmit pending with transmit enable set, receive pending with receive mode 01 or 10, or break enable set with break status set.
- R9: The external pending bit of a channel (bit 3 for A, bit 0 for B) shows, one cycle later, break enable AND break status of that channel.
- R10: A data write sets that channel's transmit-empty and all-sent status bits, which stay set until reset.
- R11: Within a channel only one strobe acts per cycle, in priority order: received, read, transmit event, clear-transmit, reset-under-service. When both channels update the vector in the same cycle, channel A's code is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_rx_char | input | 2 | Character received strobe per channel (bit 1 = A, bit 0 = B) |
| ch_rx_read | input | 2 | Data port read strobe per channel |
| ch_tx_write | input | 2 | Data port write strobe per channel |
| ch_tx_empty | input | 2 | Transmit buffer empty strobe per channel |
| cmd_clr_tx | input | 2 | Clear transmit pending command per channel |
| cmd_rst_ius | input | 2 | Reset highest under-service command per channel |
| en_tx_irq | input | 2 | Transmit interrupt enable per channel |
| rx_irq_mode | input | 4 | Receive interrupt mode, bits [2c+1:2c] for channel c |
| en_brk_irq | input | 2 | Break interrupt enable per channel |
| brk_seen | input | 2 | Break status per channel |
| vec_stat_hi | input | 1 | 1 selects status-high vector codes |
| irq_o | output | 1 | Interrupt request, active high |
| pend_o | output | 6 | Shared pending register |
| vec_o | output | 8 | Modified interrupt vector |
| txbuf_empty_o | output | 2 | Transmit-empty status per channel |
| all_sent_o | output | 2 | All-sent status per channel |

## Verification
On every cycle the assertions check state relations: receive under service implies receive pending, a transmit pending bit implies internal transmit pending, a transmit event under receive service leaves transmit service unchanged, reads, clear-transmit and reset-under-service clear the flags they own, the vector stays within the legal code set, and an enabled transmit pending bit drives the request. The actual order of re-raising after read, clear-transmit and reset-under-service, the exact vector chosen in each mode, and the channel-A precedence on simultaneous updates are only shown by the bench's scenarios compared against its model.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int NCH    = 2;
  localparam int VEC_W  = 8;
  localparam int SLOT_W = 3;
  localparam int PEND_W = SLOT_W * NCH;
  localparam int MODE_W = 2;

  typedef enum logic [1:0] {
    VK_NONE = 2'd0,
    VK_TX   = 2'd1,
    VK_RX   = 2'd2
  } vkind_e;

  typedef struct packed {
    logic   upd;
    vkind_e kind;
  } vreq_t;
endpackage

// File: rtl/sio_irq_vecenc.sv
module sio_irq_vecenc
  import sio_irq_pkg::*;
#(
  parameter bit CHAN_A = 1'b0
) (
  input  vkind_e           kind,
  input  logic             stat_hi,
  output logic [VEC_W-1:0] code
);
  always_comb begin
    code = '0;
    unique case (kind)
      VK_RX:   code = stat_hi ? (CHAN_A ? 8'h30 : 8'h20) : (CHAN_A ? 8'h0C : 8'h04);
      VK_TX:   code = stat_hi ? (CHAN_A ? 8'h10 : 8'h00) : (CHAN_A ? 8'h08 : 8'h00);
      default: code = stat_hi ? 8'h60 : 8'h06;
    endcase
  end
endmodule

// File: rtl/sio_irq_chan.sv
module sio_irq_chan
  import sio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_char,
  input  logic              rx_read,
  input  logic              tx_write,
  input  logic              tx_empty,
  input  logic              clr_tx,
  input  logic              rst_ius,
  input  logic              tx_ie,
  input  logic [MODE_W-1:0] rx_mode,
  input  logic              brk_ie,
  input  logic              brk_st,
  output logic              req_d,
  output logic              pend_rx_q,
  output logic              pend_tx_q,
  output logic              ext_q,
  output logic              empty_q,
  output logic              sent_q,
  output vreq_t             vreq
);
  logic rxp_q, txp_q, rxs_q, txs_q;
  logic rxp_d, txp_d, rxs_d, txs_d, prx_d, ptx_d, emp_d, snt_d;
  logic take_rxc, take_rd, take_tx, take_ctx, take_ius, take_wr, st_en;
  logic rx_ie;

  assign take_rxc = rx_char;
  assign take_rd  = !rx_char && rx_read;
  assign take_tx  = !rx_char && !rx_read && (tx_write || tx_empty);
  assign take_ctx = !rx_char && !rx_read && !tx_write && !tx_empty && clr_tx;
  assign take_ius = !rx_char && !rx_read && !tx_write && !tx_empty && !clr_tx && rst_ius;
  assign take_wr  = take_tx && tx_write;
  assign st_en    = rx_char || rx_read || tx_write || tx_empty || clr_tx || rst_ius;
  assign rx_ie    = (rx_mode == 2'b01) || (rx_mode == 2'b10);

  always_comb begin
    rxp_d = rxp_q;
    txp_d = txp_q;
    rxs_d = rxs_q;
    txs_d = txs_q;
    prx_d = pend_rx_q;
    ptx_d = pend_tx_q;
    emp_d = empty_q || take_wr;
    snt_d = sent_q || take_wr;
    vreq  = '{upd: 1'b0, kind: VK_NONE};
    if (take_rxc) begin
      rxp_d = 1'b1;
      rxs_d = 1'b1;
      prx_d = 1'b1;
      vreq  = '{upd: 1'b1, kind: VK_RX};
    end else if (take_rd) begin
      rxp_d = 1'b0;
      rxs_d = 1'b0;
      prx_d = 1'b0;
      vreq  = '{upd: 1'b1, kind: VK_NONE};
      if (txp_q) begin
        txs_d = 1'b1;
        ptx_d = pend_tx_q || tx_ie;
        vreq  = '{upd: 1'b1, kind: VK_TX};
      end
    end else if (take_tx) begin
      txp_d = 1'b1;
      if (!rxs_q) begin
        txs_d = 1'b1;
        ptx_d = pend_tx_q || tx_ie;
        vreq  = '{upd: 1'b1, kind: VK_TX};
      end
    end else if (take_ctx) begin
      txp_d = 1'b0;
      txs_d = 1'b0;
      ptx_d = 1'b0;
      vreq  = '{upd: 1'b1, kind: VK_NONE};
      if (rxp_q) begin
        rxs_d = 1'b1;
        prx_d = 1'b1;
        vreq  = '{upd: 1'b1, kind: VK_RX};
      end
    end else if (take_ius) begin
      if (rxs_q) begin
        rxs_d = 1'b0;
        if (txp_q) begin
          txs_d = 1'b1;
          ptx_d = pend_tx_q || tx_ie;
          vreq  = '{upd: 1'b1, kind: VK_TX};
        end
      end else if (txs_q) begin
        txs_d = 1'b0;
      end
    end
    req_d = (tx_ie && txp_d) || (rx_ie && rxp_d) || (brk_ie && brk_st);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxp_q     <= 1'b0;
      txp_q     <= 1'b0;
      rxs_q     <= 1'b0;
      txs_q     <= 1'b0;
      pend_rx_q <= 1'b0;
      pend_tx_q <= 1'b0;
      empty_q   <= 1'b0;
      sent_q    <= 1'b0;
    end else if (st_en) begin
      rxp_q     <= rxp_d;
      txp_q     <= txp_d;
      rxs_q     <= rxs_d;
      txs_q     <= txs_d;
      pend_rx_q <= prx_d;
      pend_tx_q <= ptx_d;
      empty_q   <= emp_d;
      sent_q    <= snt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= brk_ie && brk_st;
  end

  AST_RXSVC_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    rxs_q |-> rxp_q); // R2
  AST_TXBIT_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_tx_q |-> txp_q); // R3
  AST_TX_HELD_BY_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (take_tx && rxs_q) |=> (txs_q == $past(txs_q))); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    take_rd |=> (!rxp_q && !rxs_q && !pend_rx_q)); // R5
  AST_CLRTX_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    take_ctx |=> (!txp_q && !txs_q && !pend_tx_q)); // R6
  AST_IUS_RX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ius && rxs_q) |=> !rxs_q); // R7
  AST_WRITE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    take_wr |=> (empty_q && sent_q)); // R10
endmodule

// File: rtl/sio_irq_vec.sv
module sio_irq_vec
  import sio_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        ch_rx_char,
  input  logic [NCH-1:0]        ch_rx_read,
  input  logic [NCH-1:0]        ch_tx_write,
  input  logic [NCH-1:0]        ch_tx_empty,
  input  logic [NCH-1:0]        cmd_clr_tx,
  input  logic [NCH-1:0]        cmd_rst_ius,
  input  logic [NCH-1:0]        en_tx_irq,
  input  logic [NCH*MODE_W-1:0] rx_irq_mode,
  input  logic [NCH-1:0]        en_brk_irq,
  input  logic [NCH-1:0]        brk_seen,
  input  logic                  vec_stat_hi,
  output logic                  irq_o,
  output logic [PEND_W-1:0]     pend_o,
  output logic [VEC_W-1:0]      vec_o,
  output logic [NCH-1:0]        txbuf_empty_o,
  output logic [NCH-1:0]        all_sent_o
);
  logic [NCH-1:0]   req_d;
  vreq_t            vreq  [NCH];
  logic [VEC_W-1:0] vcode [NCH];
  logic [VEC_W-1:0] vec_d;
  logic             vec_en;
  logic             irq_q;
  logic [VEC_W-1:0] vec_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sio_irq_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_char   (ch_rx_char[c]),
      .rx_read   (ch_rx_read[c]),
      .tx_write  (ch_tx_write[c]),
      .tx_empty  (ch_tx_empty[c]),
      .clr_tx    (cmd_clr_tx[c]),
      .rst_ius   (cmd_rst_ius[c]),
      .tx_ie     (en_tx_irq[c]),
      .rx_mode   (rx_irq_mode[c*MODE_W +: MODE_W]),
      .brk_ie    (en_brk_irq[c]),
      .brk_st    (brk_seen[c]),
      .req_d     (req_d[c]),
      .pend_rx_q (pend_o[c*SLOT_W + 2]),
      .pend_tx_q (pend_o[c*SLOT_W + 1]),
      .ext_q     (pend_o[c*SLOT_W]),
      .empty_q   (txbuf_empty_o[c]),
      .sent_q    (all_sent_o[c]),
      .vreq      (vreq[c])
    );
    sio_irq_vecenc #(.CHAN_A(c == 1)) u_enc (
      .kind    (vreq[c].kind),
      .stat_hi (vec_stat_hi),
      .code    (vcode[c])
    );
  end

  // Higher index (channel A) is applied last and so takes precedence.
  always_comb begin
    vec_en = 1'b0;
    vec_d  = vec_q;
    for (int c = 0; c < NCH; c++) begin
      if (vreq[c].upd) begin
        vec_en = 1'b1;
        vec_d  = vcode[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_en) vec_q <= vec_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |req_d;
  end

  assign irq_o = irq_q;
  assign vec_o = vec_q;

  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_o inside {8'h00, 8'h04, 8'h06, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h30, 8'h60})); // R4
  AST_TXA_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o[4] && $past(en_tx_irq[1])) |-> irq_o); // R8
  AST_TXB_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o[1] && $past(en_tx_irq[0])) |-> irq_o); // R8
endmodule

// File: tb/sio_irq_vec_test.sv
module sio_irq_vec_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] rxc, rrd, twr, tem, ctx, ius, tie, bie, bst;
  logic [3:0] rmode;
  logic       shi;
  logic       irq;
  logic [5:0] pend;
  logic [7:0] vec;
  logic [1:0] emp, snt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model state
  logic [1:0] m_rxp, m_txp, m_rxs, m_txs, m_prx, m_ptx, m_ext, m_emp, m_snt;
  logic [7:0] m_vec;
  logic       m_irq;

  always #5 clk = ~clk;

  sio_irq_vec uut (
    .clk(clk), .rst_n(rst_n),
    .ch_rx_char(rxc), .ch_rx_read(rrd), .ch_tx_write(twr), .ch_tx_empty(tem),
    .cmd_clr_tx(ctx), .cmd_rst_ius(ius), .en_tx_irq(tie), .rx_irq_mode(rmode),
    .en_brk_irq(bie), .brk_seen(bst), .vec_stat_hi(shi),
    .irq_o(irq), .pend_o(pend), .vec_o(vec), .txbuf_empty_o(emp), .all_sent_o(snt)
  );

  // R4 code table
  function automatic logic [7:0] vcode(int kind, int c, logic hi);
    if (kind == 2) return hi ? (c == 1 ? 8'h30 : 8'h20) : (c == 1 ? 8'h0C : 8'h04);
    if (kind == 1) return hi ? (c == 1 ? 8'h10 : 8'h00) : (c == 1 ? 8'h08 : 8'h00);
    return hi ? 8'h60 : 8'h06;
  endfunction

  function automatic logic [5:0] m_pend();
    return {m_prx[1], m_ptx[1], m_ext[1], m_prx[0], m_ptx[0], m_ext[0]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rxp = '0; m_txp = '0; m_rxs = '0; m_txs = '0; m_prx = '0;
      m_ptx = '0; m_ext = '0; m_emp = '0; m_snt = '0; m_vec = '0; m_irq = 1'b0;
    end else begin
      logic r;
      r = 1'b0;
      for (int c = 0; c < 2; c++) begin
        logic upd;
        int   k;
        upd = 1'b0; k = 0;
        if (rxc[c]) begin                                   // R2, R11 priority
          m_rxp[c] = 1; m_rxs[c] = 1; m_prx[c] = 1; upd = 1; k = 2;
        end else if (rrd[c]) begin                          // R5
          m_rxp[c] = 0; m_rxs[c] = 0; m_prx[c] = 0; upd = 1; k = 0;
          if (m_txp[c]) begin m_txs[c] = 1; if (tie[c]) m_ptx[c] = 1; k = 1; end
        end else if (twr[c] || tem[c]) begin                // R3, R10
          m_txp[c] = 1;
          if (twr[c]) begin m_emp[c] = 1; m_snt[c] = 1; end
          if (!m_rxs[c]) begin m_txs[c] = 1; if (tie[c]) m_ptx[c] = 1; upd = 1; k = 1; end
        end else if (ctx[c]) begin                          // R6
          m_txp[c] = 0; m_txs[c] = 0; m_ptx[c] = 0; upd = 1; k = 0;
          if (m_rxp[c]) begin m_rxs[c] = 1; m_prx[c] = 1; k = 2; end
        end else if (ius[c]) begin                          // R7
          if (m_rxs[c]) begin
            m_rxs[c] = 0;
            if (m_txp[c]) begin m_txs[c] = 1; if (tie[c]) m_ptx[c] = 1; upd = 1; k = 1; end
          end else if (m_txs[c]) m_txs[c] = 0;
        end
        if (upd) m_vec = vcode(k, c, shi);                  // R11: A (c=1) last
        m_ext[c] = bie[c] && bst[c];                        // R9
        r = r || (tie[c] && m_txp[c]) ||
            ((rmode[2*c +: 2] == 2'b01 || rmode[2*c +: 2] == 2'b10) && m_rxp[c]) ||
            (bie[c] && bst[c]);                             // R8
      end
      m_irq = r;
    end
  end

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "pend(R2)", {2'b0, pend}, {2'b0, m_pend()});
    chk(tag, "vec(R4)", vec, m_vec);
    chk(tag, "irq(R8)", {7'b0, irq}, {7'b0, m_irq});
    chk(tag, "status(R10)", {4'b0, emp, snt}, {4'b0, m_emp, m_snt});
  endtask

  task automatic clr_strobes();
    rxc = '0; rrd = '0; twr = '0; tem = '0; ctx = '0; ius = '0;
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
    clr_strobes();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    clr_strobes();
    tie = '0; bie = '0; bst = '0; rmode = '0; shi = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1");
    chk("R1", "vec_zero", vec, 8'h00);
    rst_n = 1'b1;

    // R2: status-low receive on channel A
    tie = 2'b11; rmode = 4'b0101;
    rxc[1] = 1; cyc("R2");
    chk("R2", "vecA_rx", vec, 8'h0C);
    // R3: transmit event while receive under service keeps vector
    tem[1] = 1; cyc("R3");
    chk("R3", "vec_held", vec, 8'h0C);
    // R7: reset-IUS hands vector to pending transmit
    ius[1] = 1; cyc("R7");
    chk("R7", "vecA_tx", vec, 8'h08);
    ius[1] = 1; cyc("R7");
    // R5: read with transmit still pending
    rrd[1] = 1; cyc("R5");
    chk("R5", "vec_tx_again", vec, 8'h08);
    // R6: clear transmit, no receive left
    ctx[1] = 1; cyc("R6");
    chk("R6", "vec_none_lo", vec, 8'h06);
    // R6: clear transmit with receive pending re-raises receive
    rxc[0] = 1; cyc("R2");
    tem[0] = 1; cyc("R3");
    ctx[0] = 1; cyc("R6");
    chk("R6", "vecB_rx", vec, 8'h04);
    // R4: status-high codes
    shi = 1'b1;
    rrd[0] = 1; cyc("R4");
    chk("R4", "vec_none_hi", vec, 8'h60);
    rxc[0] = 1; cyc("R4");
    chk("R4", "vecB_rx_hi", vec, 8'h20);
    rrd[0] = 1; cyc("R4");
    tem[1] = 1; cyc("R4");
    chk("R4", "vecA_tx_hi", vec, 8'h10);
    // R9: break
    tie = 2'b00; rmode = 4'b0000; ctx[1] = 1; cyc("R9");
    bie[0] = 1; bst[0] = 1; cyc("R9");
    chk("R9", "extB", {7'b0, pend[0]}, 8'h01);
    bst[0] = 0; cyc("R9");
    // R10: data write status
    twr[0] = 1; cyc("R10");
    chk("R10", "emptyB", {6'b0, emp}, 8'h01);
    // R11: simultaneous channel updates and same-channel priority
    rxc = 2'b11; cyc("R11");
    chk("R11", "A_wins", vec, 8'h30);
    rrd[1] = 1; ctx[1] = 1; cyc("R11");
    rxc[0] = 1; rrd[0] = 1; twr[0] = 1; cyc("R11");

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      int sel;
      if ($urandom_range(0, 7) == 0) begin
        tie = 2'($urandom); rmode = 4'($urandom); bie = 2'($urandom); shi = 1'($urandom);
      end
      if ($urandom_range(0, 5) == 0) bst = 2'($urandom);
      sel = $urandom_range(0, 13);
      if (sel < 12) begin
        int c;
        c = sel % 2;
        case (sel / 2)
          0: rxc[c] = 1;
          1: rrd[c] = 1;
          2: twr[c] = 1;
          3: tem[c] = 1;
          4: ctx[c] = 1;
          default: ius[c] = 1;
        endcase
      end else if (sel == 12) begin
        rxc = 2'($urandom); rrd = 2'($urandom); tem = 2'($urandom); ius = 2'($urandom);
      end
      cyc("RND");
    end
    finish_run();
  end
endmodule